// File: doc/BRIEF.md
# Fast A20 Gate Monitor

This block watches I/O writes aimed at the keyboard controller and handles the fast A20 gate command itself, so the external controller never has to. A write of the gate command byte to the keyboard command port arms the monitor. The next write to the keyboard data port then sets the A20 mask output when the gate bit is 1, or clears it when that bit is 0. The mask is sticky. It changes only when a completed sequence, a write to the system control port, a warm reset (if enabled) or a cold reset acts on it.

The block also marks which keyboard-port writes still have to reach the real keyboard controller. When the monitor is enabled, the data-port write that completes a gate sequence is absorbed by the block. Every other keyboard-port write is passed on. When the monitor is disabled, the block leaves the gate sequence alone and passes on every keyboard-port write. The configuration bits come from a register owned elsewhere, which holds the monitor-enable bit set after reset.

Top module: `a20_gate_snoop`

## Requirements
- R1: Cold reset (`rst` high, sampled at a clock edge) leaves `a20_mask_o` and `kbd_fwd_o` at 0 after that edge and leaves the sequence disarmed. A data-port write after reset therefore has no effect on the mask.
- R2: With the monitor enabled, a write of D1h to port 064h followed by a write to port 060h with data bit 1 = 1 drives `a20_mask_o` to 1 from the clock edge that samples the data-port write.
- R3: With the monitor enabled, a write of D1h to port 064h followed by a write to port 060h with data bit 1 = 0 drives `a20_mask_o` to 0 from the edge that samples the data-port write.
- R4: `a20_mask_o` holds its value across idle cycles and across port 060h writes that do not follow an armed command. It also holds across writes to other ports, apart from port 092h.
- R5: Any write to port 092h clears `a20_mask_o` at the next edge, whatever the data and whatever the monitor-enable setting.
- R6: A cycle with `warm_rst_i` high clears `a20_mask_o` at the next edge when `cfg_warm_clr_en_i` is 1. When that bit is 0, the warm reset leaves the mask unchanged.
- R7: The armed state lasts only until the next write to port 060h or 064h. A write to 064h with any data other than D1h disarms it. Writes to ports other than 060h and 064h do not disarm it.
- R8: With `cfg_monitor_en_i` at 0, the block never arms and never changes the mask through the keyboard ports. A D1h written while disabled does not arm a later data write made after the monitor is re-enabled.
- R9: `kbd_fwd_o` is a one-cycle pulse in the cycle after each write to port 060h or 064h. The exception is the data write that completes an armed sequence with the monitor enabled, which gets no pulse. Writes to any other port never produce a pulse.
- R10: A cycle with `warm_rst_i` high disarms the sequence, whatever `cfg_warm_clr_en_i` is set to. A data-port write in that same cycle is forwarded and does not change the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| warm_rst_i | input | 1 | Warm reset indication, sampled each cycle |
| cfg_monitor_en_i | input | 1 | 1 = fast gate sequence handled by this block |
| cfg_warm_clr_en_i | input | 1 | 1 = warm reset forces the mask off |
| io_wr_i | input | 1 | I/O write strobe, one write per cycle |
| io_addr_i | input | ADDR_W (16) | I/O write port address |
| io_data_i | input | DATA_W (8) | I/O write data |
| a20_mask_o | output | 1 | A20 mask, 1 = address bit 20 forced low |
| kbd_fwd_o | output | 1 | Pulse: previous cycle's keyboard-port write goes to the keyboard controller |

## Verification
The assertions check on every cycle that a mask rise is always preceded by a gate-bit data write with the monitor enabled. They also check that a write to 092h and an enabled warm reset always leave the mask low, that a quiet cycle never moves the mask, and that a forward pulse only ever follows a keyboard-port write. The ordering rules need the bench's scenarios. These cover disarming by a wrong command byte or by a data write, the survival of the armed state across unrelated ports, a D1h written while disabled that must not complete after re-enable, and a warm reset that disarms without clearing.

// File: rtl/a20_snoop_pkg.sv
package a20_snoop_pkg;

    // Sequence state of the gate command monitor.
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    // Classification of the current I/O write.
    typedef struct packed {
        logic kbd_data;    // write to the keyboard data port
        logic kbd_cmd;     // write to the keyboard command port
        logic sysctl;      // write to the system control port
        logic cmd_is_gate; // data equals the gate command byte
        logic gate_bit;    // value of the gate data bit
    } io_class_t;

    // Events from the sequence monitor to the mask register.
    typedef struct packed {
        logic set_mask;
        logic clr_mask;
        logic consume;     // completing data write is absorbed
    } seq_evt_t;

    // True when the write touches either keyboard port.
    function automatic logic is_kbd_write(input io_class_t c);
        return c.kbd_data | c.kbd_cmd;
    endfunction

endpackage

// File: rtl/a20_port_decode.sv
module a20_port_decode
    import a20_snoop_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] KBD_DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] KBD_CMD_PORT  = 16'h0064,
    parameter logic [ADDR_W-1:0] SYSCTL_PORT   = 16'h0092,
    parameter logic [DATA_W-1:0] GATE_CMD      = 8'hD1,
    parameter int unsigned GATE_BIT = 1
) (
    input  logic              io_wr_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic [DATA_W-1:0] io_data_i,
    output io_class_t         cls_o
);
    localparam int unsigned N_PORTS = 3;
    localparam logic [N_PORTS-1:0][ADDR_W-1:0] PORT_TAB =
        {SYSCTL_PORT, KBD_CMD_PORT, KBD_DATA_PORT};

    logic [N_PORTS-1:0] hit;

    for (genvar gi = 0; gi < N_PORTS; gi++) begin : g_match
        assign hit[gi] = io_wr_i && (io_addr_i == PORT_TAB[gi]);
    end

    always_comb begin
        cls_o.kbd_data    = hit[0];
        cls_o.kbd_cmd     = hit[1];
        cls_o.sysctl      = hit[2];
        cls_o.cmd_is_gate = (io_data_i == GATE_CMD);
        cls_o.gate_bit    = io_data_i[GATE_BIT];
    end
endmodule

// File: rtl/a20_seq_fsm.sv
module a20_seq_fsm
    import a20_snoop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      warm_rst_i,
    input  logic      mon_en_i,
    input  io_class_t cls_i,
    output seq_evt_t  evt_o
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        evt_o   = '0;
        if (warm_rst_i || !mon_en_i) begin
            state_d = SEQ_IDLE;
        end else if (cls_i.kbd_cmd) begin
            state_d = cls_i.cmd_is_gate ? SEQ_ARMED : SEQ_IDLE;
        end else if (cls_i.kbd_data) begin
            state_d = SEQ_IDLE;
            if (state_q == SEQ_ARMED) begin
                evt_o.consume  = 1'b1;
                evt_o.set_mask = cls_i.gate_bit;
                evt_o.clr_mask = !cls_i.gate_bit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/a20_mask_reg.sv
module a20_mask_reg
    import a20_snoop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     warm_rst_i,
    input  logic     warm_clr_en_i,
    input  logic     sysctl_wr_i,
    input  seq_evt_t evt_i,
    output logic     mask_o
);
    logic mask_d;

    // Later assignments win: warm clear has the highest priority.
    always_comb begin
        mask_d = mask_o;
        if (evt_i.set_mask) mask_d = 1'b1;
        if (evt_i.clr_mask) mask_d = 1'b0;
        if (sysctl_wr_i)    mask_d = 1'b0;
        if (warm_rst_i && warm_clr_en_i) mask_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_o <= 1'b0;
        else     mask_o <= mask_d;
    end
endmodule

// File: rtl/a20_gate_snoop.sv
module a20_gate_snoop
    import a20_snoop_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] KBD_DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] KBD_CMD_PORT  = 16'h0064,
    parameter logic [ADDR_W-1:0] SYSCTL_PORT   = 16'h0092,
    parameter logic [DATA_W-1:0] GATE_CMD      = 8'hD1,
    parameter int unsigned GATE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst_i,
    input  logic              cfg_monitor_en_i,
    input  logic              cfg_warm_clr_en_i,
    input  logic              io_wr_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic [DATA_W-1:0] io_data_i,
    output logic              a20_mask_o,
    output logic              kbd_fwd_o
);
    io_class_t cls;
    seq_evt_t  evt;

    a20_port_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .KBD_DATA_PORT(KBD_DATA_PORT), .KBD_CMD_PORT(KBD_CMD_PORT),
        .SYSCTL_PORT(SYSCTL_PORT), .GATE_CMD(GATE_CMD), .GATE_BIT(GATE_BIT)
    ) u_decode (
        .io_wr_i  (io_wr_i),
        .io_addr_i(io_addr_i),
        .io_data_i(io_data_i),
        .cls_o    (cls)
    );

    a20_seq_fsm u_seq (
        .clk       (clk),
        .rst       (rst),
        .warm_rst_i(warm_rst_i),
        .mon_en_i  (cfg_monitor_en_i),
        .cls_i     (cls),
        .evt_o     (evt)
    );

    a20_mask_reg u_mask (
        .clk          (clk),
        .rst          (rst),
        .warm_rst_i   (warm_rst_i),
        .warm_clr_en_i(cfg_warm_clr_en_i),
        .sysctl_wr_i  (cls.sysctl),
        .evt_i        (evt),
        .mask_o       (a20_mask_o)
    );

    always_ff @(posedge clk) begin
        if (rst) kbd_fwd_o <= 1'b0;
        else     kbd_fwd_o <= is_kbd_write(cls) && !evt.consume;
    end
endmodule

// File: rtl/a20_gate_snoop_chk.sv
module a20_gate_snoop_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 8,
    parameter logic [ADDR_W-1:0] KBD_DATA_PORT = 16'h0060,
    parameter logic [ADDR_W-1:0] KBD_CMD_PORT  = 16'h0064,
    parameter logic [ADDR_W-1:0] SYSCTL_PORT   = 16'h0092,
    parameter int unsigned GATE_BIT = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              warm_rst_i,
    input logic              cfg_monitor_en_i,
    input logic              cfg_warm_clr_en_i,
    input logic              io_wr_i,
    input logic [ADDR_W-1:0] io_addr_i,
    input logic [DATA_W-1:0] io_data_i,
    input logic              a20_mask_o,
    input logic              kbd_fwd_o
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!a20_mask_o && !kbd_fwd_o));

    // R2
    mask_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(a20_mask_o) |-> $past(io_wr_i && io_addr_i == KBD_DATA_PORT
                                    && io_data_i[GATE_BIT] && cfg_monitor_en_i));

    // R4
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!io_wr_i && !warm_rst_i) |=> $stable(a20_mask_o));

    // R5
    sysctl_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (io_wr_i && io_addr_i == SYSCTL_PORT) |=> !a20_mask_o);

    // R6
    warm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_rst_i && cfg_warm_clr_en_i) |=> !a20_mask_o);

    // R8
    disabled_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_monitor_en_i && io_wr_i && io_addr_i == KBD_DATA_PORT) |=> kbd_fwd_o);

    // R9
    fwd_src_chk: assert property (@(posedge clk) disable iff (rst)
        kbd_fwd_o |-> $past(io_wr_i && (io_addr_i == KBD_DATA_PORT
                                        || io_addr_i == KBD_CMD_PORT)));
endmodule

bind a20_gate_snoop a20_gate_snoop_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KBD_DATA_PORT(KBD_DATA_PORT), .KBD_CMD_PORT(KBD_CMD_PORT),
    .SYSCTL_PORT(SYSCTL_PORT), .GATE_BIT(GATE_BIT)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .warm_rst_i       (warm_rst_i),
    .cfg_monitor_en_i (cfg_monitor_en_i),
    .cfg_warm_clr_en_i(cfg_warm_clr_en_i),
    .io_wr_i          (io_wr_i),
    .io_addr_i        (io_addr_i),
    .io_data_i        (io_data_i),
    .a20_mask_o       (a20_mask_o),
    .kbd_fwd_o        (kbd_fwd_o)
);

// File: tb/test_a20_gate_snoop.sv
module test_a20_gate_snoop;
    localparam logic [15:0] PD = 16'h0060;
    localparam logic [15:0] PC = 16'h0064;
    localparam logic [15:0] PS = 16'h0092;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, warm = 1'b0, mon_en = 1'b1, wclr_en = 1'b1, wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  data = '0;
    logic mask, fwd;

    a20_gate_snoop i_a20_gate_snoop (
        .clk(clk), .rst(rst), .warm_rst_i(warm),
        .cfg_monitor_en_i(mon_en), .cfg_warm_clr_en_i(wclr_en),
        .io_wr_i(wr), .io_addr_i(addr), .io_data_i(data),
        .a20_mask_o(mask), .kbd_fwd_o(fwd)
    );

    typedef struct {
        logic  m;
        logic  f;
        string req;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // Driver: apply one cycle of stimulus, push the result expected after the edge.
    task automatic cyc(input logic r, input logic w, input logic [15:0] a,
                       input logic [7:0] d, input logic wm,
                       input logic em, input logic ef, input string req);
        @(negedge clk);
        rst = r; wr = w; addr = a; data = d; warm = wm;
        @(posedge clk);
        #1;
        q.push_back('{em, ef, req});
    endtask

    task automatic iow(input logic [15:0] a, input logic [7:0] d,
                       input logic em, input logic ef, input string req);
        cyc(1'b0, 1'b1, a, d, 1'b0, em, ef, req);
    endtask

    task automatic idle(input logic em, input string req);
        cyc(1'b0, 1'b0, 16'h0, 8'h0, 1'b0, em, 1'b0, req);
    endtask

    // Monitor: compare outputs against the scoreboard away from the edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (mask !== e.m || fwd !== e.f) begin
                n_bad++;
                $display("FAIL %s: actual mask=%b fwd=%b expected mask=%b fwd=%b",
                         e.req, mask, fwd, e.m, e.f);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cyc(1'b1, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, "R1");
        cyc(1'b1, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, "R1");
        idle(1'b0, "R1");
        iow(PD, 8'h02, 1'b0, 1'b1, "R1");       // not armed after reset

        // R2 set sequence, R9 consumed data write
        iow(PC, 8'hD1, 1'b0, 1'b1, "R9");
        iow(PD, 8'h02, 1'b1, 1'b0, "R2");
        idle(1'b1, "R4");
        iow(PD, 8'h02, 1'b1, 1'b1, "R4");
        iow(PD, 8'h00, 1'b1, 1'b1, "R4");       // unarmed clear attempt ignored
        iow(16'h0070, 8'h00, 1'b1, 1'b0, "R9");  // other port: no pulse
        // R3 clear sequence
        iow(PC, 8'hD1, 1'b1, 1'b1, "R3");
        iow(PD, 8'h00, 1'b0, 1'b0, "R3");

        // R7 disarm by another command
        iow(PC, 8'hD1, 1'b0, 1'b1, "R7");
        iow(PC, 8'hAA, 1'b0, 1'b1, "R7");
        iow(PD, 8'h02, 1'b0, 1'b1, "R7");
        // R7 other ports keep the arm
        iow(PC, 8'hD1, 1'b0, 1'b1, "R7");
        iow(16'h0070, 8'h00, 1'b0, 1'b0, "R7");
        iow(PD, 8'hFF, 1'b1, 1'b0, "R7");
        // R7 data write disarms
        iow(PD, 8'h00, 1'b1, 1'b1, "R7");

        // R5 system control port clear
        iow(PS, 8'h00, 1'b0, 1'b0, "R5");

        // R6 warm reset with clear enabled
        iow(PC, 8'hD1, 1'b0, 1'b1, "R6");
        iow(PD, 8'h02, 1'b1, 1'b0, "R6");
        cyc(1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b0, 1'b0, "R6");
        // R6 warm reset with clear disabled
        iow(PC, 8'hD1, 1'b0, 1'b1, "R6");
        iow(PD, 8'h02, 1'b1, 1'b0, "R6");
        wclr_en = 1'b0;
        cyc(1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b1, 1'b0, "R6");
        // R10 warm reset disarms even when it does not clear
        iow(PC, 8'hD1, 1'b1, 1'b1, "R10");
        cyc(1'b0, 1'b0, 16'h0, 8'h0, 1'b1, 1'b1, 1'b0, "R10");
        iow(PD, 8'h00, 1'b1, 1'b1, "R10");
        iow(PC, 8'hD1, 1'b1, 1'b1, "R10");
        cyc(1'b0, 1'b1, PD, 8'h00, 1'b1, 1'b1, 1'b1, "R10");
        wclr_en = 1'b1;
        iow(PS, 8'hFF, 1'b0, 1'b0, "R5");

        // R8 monitor disabled
        mon_en = 1'b0;
        iow(PC, 8'hD1, 1'b0, 1'b1, "R8");
        iow(PD, 8'h02, 1'b0, 1'b1, "R8");
        iow(PC, 8'hD1, 1'b0, 1'b1, "R8");
        mon_en = 1'b1;
        iow(PD, 8'h02, 1'b0, 1'b1, "R8");
        iow(PC, 8'hD1, 1'b0, 1'b1, "R8");
        iow(PD, 8'h02, 1'b1, 1'b0, "R8");
        mon_en = 1'b0;
        iow(PC, 8'hD1, 1'b1, 1'b1, "R8");
        iow(PD, 8'h00, 1'b1, 1'b1, "R8");
        iow(PS, 8'h00, 1'b0, 1'b0, "R5");
        mon_en = 1'b1;

        // R1 cold reset mid-sequence
        iow(PC, 8'hD1, 1'b0, 1'b1, "R1");
        iow(PD, 8'h02, 1'b1, 1'b0, "R1");
        iow(PC, 8'hD1, 1'b1, 1'b1, "R1");
        cyc(1'b1, 1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 1'b0, "R1");
        iow(PD, 8'h02, 1'b0, 1'b1, "R1");
        idle(1'b0, "R4");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule